// File: doc/BRIEF.md
# Interrupt Dispatch Controller

This block sits beside a CPU core and decides when the core must break off its instruction stream to service an interrupt. It keeps a global enable flag, a five-bit source mask and a five-bit pending register. Peripherals raise pending bits with single-cycle request pulses, and any bus master may overwrite the mask or the pending bits. The core supplies an instruction-boundary strobe and a free-running T-state count. Four T-states make one machine cycle.

A dispatch is decided only at the last T-state of an instruction, from the registered request state. Once started, it runs for five machine cycles. The target vector is not fixed at the decision. It is taken from the live set of requests (pending AND mask) at the end of the fourth machine cycle. A write to the pending or mask register in between can therefore redirect the jump to another source. It can also send the jump to address 0 when no request survives. Only the pending bit of the source actually chosen is cleared. The core uses `dispatch_o` to stall its normal fetch and jumps to `vector_o` when the sequence ends.

Top module: `irqd_top`

## Requirements
- R1: After reset the enable flag, pending register and mask are all zero; `dispatch_o`, `vector_o` and `ack_o` are zero.
- R2: A pulse on `ime_set_i` sets the enable flag and a pulse on `ime_clr_i` clears it. Clear wins when both arrive in the same cycle. The flag is cleared automatically in the cycle a dispatch starts.
- R3: A dispatch starts only when `instr_end_i` is high in a cycle with `tstate_i` = 3, the enable flag is set and (pending AND mask) is nonzero. `dispatch_o` rises in the following cycle.
- R4: A pending bit that is set and then written back to zero before the boundary starts no dispatch. A request pulse in the boundary cycle itself is not seen at that boundary and is taken at the next one.
- R5: `dispatch_o` stays high for exactly 20 consecutive clock cycles, which is five machine cycles.
- R6: At the last T-state of the fourth dispatch machine cycle, the lowest set bit n of (pending AND mask) selects the vector 0x40 + 8*n. Bit 0 has the highest priority. The vector is visible on `vector_o` from the next cycle.
- R7: Pending or mask writes made during machine cycles 1 to 3 of a dispatch change the chosen vector to the one for the new lowest set bit.
- R8: If (pending AND mask) is zero when the vector is chosen, `vector_o` becomes 0, `ack_o` stays zero and the pending register is left unchanged.
- R9: When a vector is chosen, only that source's pending bit is cleared. `ack_o` shows that bit one-hot for exactly one cycle.
- R10: A pending write loads `wr_data_i`, and request pulses are ORed on top of it. A request that arrives in the cycle its bit is being cleared leaves the bit set.
- R11: `instr_end_i` asserted when `tstate_i` is not 3 starts no dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tstate_i | input | 2 | T-state index within the machine cycle (3 = last) |
| instr_end_i | input | 1 | Current machine cycle is the last of an instruction |
| req_i | input | 5 | Per-source request pulses |
| wr_pend_i | input | 1 | Load pending register from `wr_data_i` |
| wr_mask_i | input | 1 | Load mask register from `wr_data_i` |
| wr_data_i | input | 5 | Write data for the pending or mask register |
| ime_set_i | input | 1 | Set global enable |
| ime_clr_i | input | 1 | Clear global enable |
| dispatch_o | output | 1 | Dispatch sequence in progress |
| vector_o | output | 16 | Jump target chosen by the latest dispatch |
| ack_o | output | 5 | One-cycle one-hot acknowledge of the serviced source |
| pend_o | output | 5 | Current pending register |
| ime_o | output | 1 | Current global enable flag |

## Verification
The assertions check on every cycle that a dispatch begins only after an enabled instruction boundary on T-state 3 and that it clears the enable flag. They also check that it lasts exactly 20 cycles, and that the acknowledge is one-hot, arrives only 16 cycles into the sequence and never comes with a zero vector. Whether the vector is the right one is left to the bench. It sweeps every pending pattern and every mask value, applies pending overwrites in the middle of a dispatch to show redirection and the fall-back to address 0, and sets up the late-request and withdrawn-request boundary cases.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    typedef logic [1:0] tstate_t;
    localparam tstate_t TS_LAST = 2'd3;
    localparam int unsigned TS_PER_MC = 4;
endpackage

// File: rtl/irqd_pick.sv
module irqd_pick #(
    parameter int unsigned NSRC     = 5,
    parameter int unsigned VEC_W    = 16,
    parameter int unsigned VEC_BASE = 64,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic [NSRC-1:0]  live_i,
    output logic [NSRC-1:0]  hit_oh_o,
    output logic [VEC_W-1:0] vec_o
);
    // lowest set bit isolates the winning source
    assign hit_oh_o = live_i & (~live_i + NSRC'(1));

    always_comb begin
        vec_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live_i[i]) vec_o = VEC_W'(VEC_BASE + VEC_STEP * i);
        end
    end
endmodule

// File: rtl/irqd_regs.sv
module irqd_regs #(
    parameter int unsigned NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            wr_pend_i,
    input  logic            wr_mask_i,
    input  logic [NSRC-1:0] wr_data_i,
    input  logic            ime_set_i,
    input  logic            ime_clr_i,
    input  logic            start_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] mask_o,
    output logic            ime_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] mask;
        logic            ime;
    } regs_t;

    regs_t           r_d, r_q;
    logic [NSRC-1:0] pend_nxt;

    // per-source pending update: write, then clear, then set (set wins)
    for (genvar g = 0; g < NSRC; g++) begin : g_pend
        assign pend_nxt[g] = ((wr_pend_i ? wr_data_i[g] : r_q.pend[g]) & ~clr_i[g])
                             | req_i[g];
    end

    always_comb begin
        r_d      = r_q;
        r_d.pend = pend_nxt;
        if (wr_mask_i) r_d.mask = wr_data_i;
        if (start_i || ime_clr_i) r_d.ime = 1'b0;
        else if (ime_set_i)       r_d.ime = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pend_o = r_q.pend;
    assign mask_o = r_q.mask;
    assign ime_o  = r_q.ime;
endmodule

// File: rtl/irqd_top.sv
module irqd_top #(
    parameter int unsigned NSRC     = 5,
    parameter int unsigned VEC_W    = 16,
    parameter int unsigned VEC_BASE = 64,
    parameter int unsigned VEC_STEP = 8,
    parameter int unsigned SEQ_MC   = 5,
    parameter int unsigned PICK_MC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       tstate_i,
    input  logic             instr_end_i,
    input  logic [NSRC-1:0]  req_i,
    input  logic             wr_pend_i,
    input  logic             wr_mask_i,
    input  logic [NSRC-1:0]  wr_data_i,
    input  logic             ime_set_i,
    input  logic             ime_clr_i,
    output logic             dispatch_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [NSRC-1:0]  ack_o,
    output logic [NSRC-1:0]  pend_o,
    output logic             ime_o
);
    import irqd_pkg::*;

    localparam int unsigned MC_W = (SEQ_MC > 1) ? $clog2(SEQ_MC) : 1;

    typedef struct packed {
        logic             active;
        logic [MC_W-1:0]  mc;
        logic [VEC_W-1:0] vec;
        logic [NSRC-1:0]  ack;
    } seq_t;

    seq_t             s_d, s_q;
    logic [NSRC-1:0]  pend_q, mask_q, live, pick_oh, clr;
    logic [VEC_W-1:0] pick_vec;
    logic             ime_q, mc_end, start, pick_now, last_now;

    irqd_regs #(.NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .wr_pend_i (wr_pend_i),
        .wr_mask_i (wr_mask_i),
        .wr_data_i (wr_data_i),
        .ime_set_i (ime_set_i),
        .ime_clr_i (ime_clr_i),
        .start_i   (start),
        .clr_i     (clr),
        .pend_o    (pend_q),
        .mask_o    (mask_q),
        .ime_o     (ime_q)
    );

    assign live = pend_q & mask_q;

    irqd_pick #(
        .NSRC     (NSRC),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_pick (
        .live_i   (live),
        .hit_oh_o (pick_oh),
        .vec_o    (pick_vec)
    );

    assign mc_end   = (tstate_i == TS_LAST);
    // decision uses only the registered state at the instruction's last T-state
    assign start    = !s_q.active && instr_end_i && mc_end && ime_q && (|live);
    assign pick_now = s_q.active && mc_end && (s_q.mc == MC_W'(PICK_MC - 1));
    assign last_now = s_q.active && mc_end && (s_q.mc == MC_W'(SEQ_MC - 1));
    assign clr      = pick_now ? pick_oh : '0;

    always_comb begin
        s_d     = s_q;
        s_d.ack = '0;
        if (start) begin
            s_d.active = 1'b1;
            s_d.mc     = '0;
        end else if (s_q.active && mc_end) begin
            if (last_now) begin
                s_d.active = 1'b0;
                s_d.mc     = '0;
            end else begin
                s_d.mc = s_q.mc + MC_W'(1);
            end
        end
        // late vector choice from the live request set
        if (pick_now) begin
            s_d.vec = pick_vec;
            s_d.ack = pick_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dispatch_o = s_q.active;
    assign vector_o   = s_q.vec;
    assign ack_o      = s_q.ack;
    assign pend_o     = pend_q;
    assign ime_o      = ime_q;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
    parameter int unsigned NSRC    = 5,
    parameter int unsigned VEC_W   = 16,
    parameter int unsigned SEQ_MC  = 5,
    parameter int unsigned PICK_MC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       tstate_i,
    input logic             instr_end_i,
    input logic             dispatch_o,
    input logic [VEC_W-1:0] vector_o,
    input logic [NSRC-1:0]  ack_o,
    input logic             ime_o
);
    localparam int unsigned LEN  = SEQ_MC * 4;
    localparam int unsigned PICK = PICK_MC * 4;

    logic [15:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (dispatch_o) cnt_q <= cnt_q + 16'd1;
        else                 cnt_q <= '0;
    end

    a_r3_start_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dispatch_o) |-> ($past(ime_o) && $past(instr_end_i) && $past(tstate_i) == 2'd3));

    a_r2_ime_cleared_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dispatch_o) |-> !ime_o);

    a_r5_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dispatch_o) |-> (cnt_q == 16'(LEN)));

    a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    a_r9_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |=> (ack_o == '0));

    a_r6_ack_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (dispatch_o && cnt_q == 16'(PICK)));

    a_r8_ack_needs_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (vector_o != '0));
endmodule

bind irqd_top irqd_checker #(
    .NSRC    (NSRC),
    .VEC_W   (VEC_W),
    .SEQ_MC  (SEQ_MC),
    .PICK_MC (PICK_MC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tstate_i    (tstate_i),
    .instr_end_i (instr_end_i),
    .dispatch_o  (dispatch_o),
    .vector_o    (vector_o),
    .ack_o       (ack_o),
    .ime_o       (ime_o)
);

// File: tb/irqd_top_bench.sv
module irqd_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tstate_i = 2'd0;
    logic        instr_end_i = 1'b0;
    logic [4:0]  req_i = '0;
    logic        wr_pend_i = 1'b0;
    logic        wr_mask_i = 1'b0;
    logic [4:0]  wr_data_i = '0;
    logic        ime_set_i = 1'b0;
    logic        ime_clr_i = 1'b0;
    logic        dispatch_o;
    logic [15:0] vector_o;
    logic [4:0]  ack_o;
    logic [4:0]  pend_o;
    logic        ime_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irqd_top u_irqd_top (
        .clk(clk), .rst_n(rst_n), .tstate_i(tstate_i), .instr_end_i(instr_end_i),
        .req_i(req_i), .wr_pend_i(wr_pend_i), .wr_mask_i(wr_mask_i),
        .wr_data_i(wr_data_i), .ime_set_i(ime_set_i), .ime_clr_i(ime_clr_i),
        .dispatch_o(dispatch_o), .vector_o(vector_o), .ack_o(ack_o),
        .pend_o(pend_o), .ime_o(ime_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_vec(input logic [4:0] v);
        exp_vec = 0;
        for (int i = 4; i >= 0; i--) if (v[i]) exp_vec = 64 + 8 * i;
    endfunction

    // advance one clock; inputs set before this call are sampled at its edge
    task automatic step();
        @(posedge clk);
        #1;
        tstate_i    = tstate_i + 2'd1;
        instr_end_i = 1'b0;
        req_i       = '0;
        wr_pend_i   = 1'b0;
        wr_mask_i   = 1'b0;
        ime_set_i   = 1'b0;
        ime_clr_i   = 1'b0;
    endtask

    task automatic write_pend(input logic [4:0] v);
        wr_pend_i = 1'b1; wr_data_i = v; step();
    endtask

    task automatic write_mask(input logic [4:0] v);
        wr_mask_i = 1'b1; wr_data_i = v; step();
    endtask

    task automatic boundary();
        while (tstate_i != 2'd3) step();
        instr_end_i = 1'b1;
        step();
    endtask

    task automatic run_disp(input string tag, input logic [4:0] p0, input logic [4:0] m0,
                            input bit mid_p, input bit mid_m, input logic [4:0] mv,
                            input bit req_pick);
        logic [4:0] p, m, live, oh, expp;
        write_pend(p0);
        write_mask(m0);
        ime_set_i = 1'b1; step();
        boundary();
        chk(dispatch_o == 1'b1, "R3", dispatch_o, 1);
        chk(ime_o == 1'b0, "R2", ime_o, 0);
        p    = mid_p ? mv : p0;
        m    = mid_m ? mv : m0;
        live = p & m;
        oh   = live & (~live + 5'd1);
        expp = (p & ~oh) | (req_pick ? 5'b00001 : 5'b0);
        for (int c = 1; c <= 20; c++) begin
            if (c == 6 && mid_p) begin wr_pend_i = 1'b1; wr_data_i = mv; end
            if (c == 6 && mid_m) begin wr_mask_i = 1'b1; wr_data_i = mv; end
            if (c == 16 && req_pick) req_i = 5'b00001;
            step();
            if (c + 1 == 17) begin
                chk(vector_o == 16'(exp_vec(live)), tag, vector_o, exp_vec(live));
                chk(ack_o == oh, "R9", ack_o, oh);
                chk(pend_o == expp, req_pick ? "R10" : "R9", pend_o, expp);
            end
            if (c + 1 == 18) chk(ack_o == 5'b0, "R9", ack_o, 0);
            if (c + 1 == 20) chk(dispatch_o == 1'b1, "R5", dispatch_o, 1);
        end
        chk(dispatch_o == 1'b0, "R5", dispatch_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(dispatch_o == 1'b0, "R1", dispatch_o, 0);
        chk(vector_o == 16'h0, "R1", vector_o, 0);
        chk(ack_o == 5'b0, "R1", ack_o, 0);
        chk(pend_o == 5'b0, "R1", pend_o, 0);
        chk(ime_o == 1'b0, "R1", ime_o, 0);

        // R2 enable commands
        ime_set_i = 1'b1; step();
        chk(ime_o == 1'b1, "R2", ime_o, 1);
        ime_clr_i = 1'b1; step();
        chk(ime_o == 1'b0, "R2", ime_o, 0);
        ime_set_i = 1'b1; step();
        ime_set_i = 1'b1; ime_clr_i = 1'b1; step();
        chk(ime_o == 1'b0, "R2", ime_o, 0);

        // R10 write with simultaneous request
        wr_pend_i = 1'b1; wr_data_i = 5'b00100; req_i = 5'b00001; step();
        chk(pend_o == 5'b00101, "R10", pend_o, 5'b00101);

        // R3 no dispatch with enable clear
        write_mask(5'h1f);
        boundary();
        step();
        chk(dispatch_o == 1'b0, "R3", dispatch_o, 0);
        // R3 no dispatch with mask zero
        write_mask(5'h00);
        ime_set_i = 1'b1; step();
        boundary();
        step();
        chk(dispatch_o == 1'b0, "R3", dispatch_o, 0);
        // R11 strobe off the last T-state
        write_mask(5'h1f);
        for (int t = 0; t < 3; t++) begin
            while (tstate_i != 2'(t)) step();
            instr_end_i = 1'b1;
            step();
            step();
            chk(dispatch_o == 1'b0, "R11", dispatch_o, 0);
        end
        // R4 withdrawn request
        write_pend(5'b00000);
        write_pend(5'b00010);
        write_pend(5'b00000);
        boundary();
        step();
        chk(dispatch_o == 1'b0, "R4", dispatch_o, 0);
        // R4 request in the boundary cycle is late
        while (tstate_i != 2'd3) step();
        instr_end_i = 1'b1; req_i = 5'b01000;
        step();
        chk(dispatch_o == 1'b0, "R4", dispatch_o, 0);
        chk(pend_o == 5'b01000, "R4", pend_o, 5'b01000);
        boundary();
        chk(dispatch_o == 1'b1, "R4", dispatch_o, 1);
        repeat (20) step();
        chk(vector_o == 16'h58, "R4", vector_o, 16'h58);

        // R6 every pending pattern with full mask
        for (int p = 1; p < 32; p++) run_disp("R6", 5'(p), 5'h1f, 1'b0, 1'b0, 5'h0, 1'b0);
        // R7 mid-dispatch pending overwrite, R8 when it empties
        for (int p = 0; p < 32; p++)
            run_disp(p == 0 ? "R8" : "R7", 5'b00001, 5'h1f, 1'b1, 1'b0, 5'(p), 1'b0);
        // R7/R8 mid-dispatch mask overwrite
        for (int m = 0; m < 32; m++)
            run_disp(m == 0 ? "R8" : "R7", 5'h1f, 5'h1f, 1'b0, 1'b1, 5'(m), 1'b0);
        // R10 request racing the clear
        run_disp("R6", 5'b00011, 5'h1f, 1'b0, 1'b0, 5'h0, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule